// File: doc/BRIEF.md
# Bytecode Fetch-Decode-Dispatch Unit

This unit drives the instruction loop of a small bytecode interpreter. It owns the bytecode program counter and fetches two-byte instructions from a byte-wide, 4 KB synchronous memory. The upper nibble of the first byte picks one of sixteen instruction groups. For groups 1 to 15 the unit builds two operand pointers into a fixed variable page and looks up the entry address of the group's handler in a fixed table. Group 0 is a native call: the 12-bit target address comes straight from the instruction.

After a fixed decode latency, which is shorter for native calls, the unit gives one start pulse. It then holds all decode results stable until the handler reports completion. When completion is reported, the handler may also overwrite the program counter. This is how it consumes the second byte or branches. The next fetch starts in the following cycle.

Top module: `bcd_dispatch`

## Requirements
- R1: While reset is low and just after it, `mem_addr` is 0x200, `hdl_start` is 0, and group, entry, native flag and both pointers are all zero.
- R2: A fetch cycle requests the byte at the program counter with `mem_rd` high and advances the counter by one. The upper nibble of that byte is presented on `hdl_group`.
- R3: For group 0, the cycle after the fetch requests the next byte and advances the counter again, so `mem_addr` ends two past the fetch address, modulo 4096. `hdl_native` is 1 and `hdl_entry` is {low nibble of first byte, second byte}.
- R4: For groups 1 to 15, the second byte is requested at the advanced address without a further advance, so `mem_addr` stays one past the fetch address until the handler finishes. `hdl_native` is 0.
- R5: For groups 1 to 15, `hdl_xptr` is 0xFF0 OR the low nibble of the first byte, and `hdl_yptr` is 0xFF0 OR the upper nibble of the second byte. Both use the default page nibble 0xF, and both are produced whether or not the instruction uses them.
- R6: A group 0 instruction leaves `hdl_xptr` and `hdl_yptr` at their previous values.
- R7: The handler entry for groups 1 through 15, in group order, is 0x17C, 0x175, 0x183, 0x18B, 0x195, 0x1B4, 0x1B7, 0x1BC, 0x191, 0x1EB, 0x1A4, 0x1D9, 0x070, 0x199, 0x105.
- R8: `hdl_start` is high for exactly one cycle. That cycle comes 40 cycles after the fetch cycle for group 0 and 68 cycles after it for every other group.
- R9: From the start pulse until completion is reported, `hdl_group`, `hdl_entry`, `hdl_native`, both pointers and `mem_addr` stay stable, and no memory read is issued.
- R10: When `hdl_done` is high in the waiting state, the next cycle is a fetch cycle. The fetch address is `pc_load_val` if `pc_load` was high together with `hdl_done`; otherwise it is the current counter value.
- R11: `hdl_done` and `pc_load` have no effect outside the waiting state. Decode timing, decode results and the program counter are unchanged.
- R12: `mem_rd` is high only in the fetch cycle and the cycle right after it. Read data is taken one cycle after each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 12 | Memory byte address (current program counter) |
| mem_rd | output | 1 | Memory read request |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| hdl_start | output | 1 | One-cycle handler start pulse |
| hdl_entry | output | 12 | Handler entry or native call address |
| hdl_group | output | 4 | Instruction group code |
| hdl_native | output | 1 | High for a group 0 native call |
| hdl_xptr | output | 12 | First operand variable pointer |
| hdl_yptr | output | 12 | Second operand variable pointer |
| hdl_done | input | 1 | Handler completion |
| pc_load | input | 1 | Load the program counter together with completion |
| pc_load_val | input | 12 | New program counter value |

## Verification
The instruction stream mixes native calls and table groups back to back. The two latencies and the two counter-advance rules must therefore each follow the instruction's own group and not the previous one. A native call placed at the top address wraps its operand read to address 0, which checks the modulo step. A sweep over all fifteen table groups, with varied nibbles, separates table entries from one another and keeps operand fields out of the group decode. Handlers of different lengths, with and without counter loads, together with a completion and load raised early during decode, show that completion matters only in the waiting state.

// File: rtl/bcd_pkg.sv
// Package: shared types and the fixed handler entry table for the
// bytecode fetch-decode-dispatch unit. Assumes a 12-bit byte address.
package bcd_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;
    localparam int GRP_W  = 4;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_BYTE1,
        ST_BYTE2,
        ST_PAD,
        ST_START,
        ST_WAIT
    } bcd_state_e;

    typedef struct packed {
        logic [GRP_W-1:0]  group;
        logic              native;
        logic [ADDR_W-1:0] entry;
        logic [ADDR_W-1:0] xptr;
        logic [ADDR_W-1:0] yptr;
    } bcd_decode_t;

    // Map a non-zero group code to its handler entry address.
    function automatic logic [ADDR_W-1:0] group_entry(input logic [GRP_W-1:0] g);
        logic [ADDR_W-1:0] e;
        case (g)
            4'h1:    e = 12'h17C;
            4'h2:    e = 12'h175;
            4'h3:    e = 12'h183;
            4'h4:    e = 12'h18B;
            4'h5:    e = 12'h195;
            4'h6:    e = 12'h1B4;
            4'h7:    e = 12'h1B7;
            4'h8:    e = 12'h1BC;
            4'h9:    e = 12'h191;
            4'hA:    e = 12'h1EB;
            4'hB:    e = 12'h1A4;
            4'hC:    e = 12'h1D9;
            4'hD:    e = 12'h070;
            4'hE:    e = 12'h199;
            4'hF:    e = 12'h105;
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/bcd_pc.sv
// Module: bytecode program counter.
// Holds the fetch address. It increments by one on request and takes a
// new value on load; load wins over increment. It wraps modulo the
// address space.
module bcd_pc
    import bcd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = 12'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] pc
);

    logic [ADDR_W-1:0] pc_q;

    // Counter update: reset, load, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else if (load) begin
            pc_q <= load_val;
        end else if (inc) begin
            pc_q <= pc_q + 1'b1;
        end
    end

    assign pc = pc_q;

endmodule

// File: rtl/bcd_decode.sv
// Module: combinational instruction decoder.
// Takes both instruction bytes and produces the group, native flag,
// entry address and the two operand pointers in the variable page.
// Assumes 8-bit bytes and 12-bit addresses.
module bcd_decode
    import bcd_pkg::*;
#(
    parameter logic [3:0] VPAGE = 4'hF
) (
    input  logic [DATA_W-1:0] byte0,
    input  logic [DATA_W-1:0] byte1,
    output bcd_decode_t       dec
);

    localparam logic [3:0] PTR_BASE = 4'hF;

    logic [GRP_W-1:0] grp;
    logic             is_nat;

    assign grp    = byte0[7:4];
    assign is_nat = (grp == '0);

    // Build the decode record from the two bytes.
    always_comb begin
        dec.group  = grp;
        dec.native = is_nat;
        dec.entry  = is_nat ? {byte0[3:0], byte1} : group_entry(grp);
        dec.xptr   = {VPAGE, PTR_BASE, byte0[3:0]};
        dec.yptr   = {VPAGE, PTR_BASE, byte1[7:4]};
    end

endmodule

// File: rtl/bcd_outreg.sv
// Module: decode result register.
// Captures the decode record on load. The operand pointers are only
// replaced for non-native groups; a native call keeps the old ones.
module bcd_outreg
    import bcd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  bcd_decode_t dec_in,
    output bcd_decode_t dec_q
);

    bcd_decode_t q;

    // Group, entry and native flag: captured on every load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.group  <= '0;
            q.native <= 1'b0;
            q.entry  <= '0;
        end else if (load) begin
            q.group  <= dec_in.group;
            q.native <= dec_in.native;
            q.entry  <= dec_in.entry;
        end
    end

    // Operand pointers: captured only for table-dispatched groups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.xptr <= '0;
            q.yptr <= '0;
        end else if (load && !dec_in.native) begin
            q.xptr <= dec_in.xptr;
            q.yptr <= dec_in.yptr;
        end
    end

    assign dec_q = q;

endmodule

// File: rtl/bcd_ctrl.sv
// Module: fetch sequencer.
// Runs fetch, second-byte read, decode capture, latency padding, start
// and wait. A cycle counter that restarts at every fetch sets the start
// cycle from the group's latency. Assumes memory returns data one cycle
// after the request and both latencies are at least 5.
module bcd_ctrl
    import bcd_pkg::*;
#(
    parameter int LAT_NATIVE = 40,
    parameter int LAT_TABLE  = 68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rdata,
    input  logic              handler_done,
    output logic              mem_rd,
    output logic              pc_inc,
    output logic              resume,
    output logic              out_load,
    output logic              start,
    output logic              waiting,
    output logic [DATA_W-1:0] byte0
);

    localparam int LAT_MAX = (LAT_NATIVE > LAT_TABLE) ? LAT_NATIVE : LAT_TABLE;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);
    localparam logic [CNT_W-1:0] LAST_NAT = CNT_W'(LAT_NATIVE - 1);
    localparam logic [CNT_W-1:0] LAST_TAB = CNT_W'(LAT_TABLE - 1);

    bcd_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] byte0_q;
    logic              nat_q;
    logic              first_is_nat;
    logic [CNT_W-1:0]  last_cnt;

    assign first_is_nat = (rdata[7:4] == '0);
    assign last_cnt     = nat_q ? LAST_NAT : LAST_TAB;

    // Next-state selection for the fetch/decode/dispatch sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_FETCH: state_d = ST_BYTE1;
            ST_BYTE1: state_d = ST_BYTE2;
            ST_BYTE2: state_d = ST_PAD;
            ST_PAD:   if (cnt_q == last_cnt) state_d = ST_START;
            ST_START: state_d = ST_WAIT;
            ST_WAIT:  if (handler_done) state_d = ST_FETCH;
            default:  state_d = ST_FETCH;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Latency counter: zero in the fetch cycle, counts every later cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d == ST_FETCH) begin
            cnt_q <= '0;
        end else if (state_q != ST_WAIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Capture the first byte and its native-call flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte0_q <= '0;
            nat_q   <= 1'b0;
        end else if (state_q == ST_BYTE1) begin
            byte0_q <= rdata;
            nat_q   <= first_is_nat;
        end
    end

    assign mem_rd   = (state_q == ST_FETCH) || (state_q == ST_BYTE1);
    assign pc_inc   = (state_q == ST_FETCH) || ((state_q == ST_BYTE1) && first_is_nat);
    assign out_load = (state_q == ST_BYTE2);
    assign start    = (state_q == ST_START);
    assign waiting  = (state_q == ST_WAIT);
    assign resume   = waiting && handler_done;
    assign byte0    = byte0_q;

endmodule

// File: rtl/bcd_dispatch.sv
// Module: bytecode fetch-decode-dispatch unit (top).
// Fetches two-byte instructions, decodes the group and operands, and
// starts the group handler or a native routine after a fixed latency.
// Assumes a synchronous byte memory with one cycle of read latency.
module bcd_dispatch
    import bcd_pkg::*;
#(
    parameter logic [11:0] RESET_PC   = 12'h200,
    parameter logic [3:0]  VPAGE      = 4'hF,
    parameter int          LAT_NATIVE = 40,
    parameter int          LAT_TABLE  = 68
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [11:0] mem_addr,
    output logic        mem_rd,
    input  logic [7:0]  mem_rdata,
    output logic        hdl_start,
    output logic [11:0] hdl_entry,
    output logic [3:0]  hdl_group,
    output logic        hdl_native,
    output logic [11:0] hdl_xptr,
    output logic [11:0] hdl_yptr,
    input  logic        hdl_done,
    input  logic        pc_load,
    input  logic [11:0] pc_load_val
);

    logic              pc_inc;
    logic              resume;
    logic              out_load;
    logic              waiting;
    logic [DATA_W-1:0] byte0;
    logic [ADDR_W-1:0] pc;
    bcd_decode_t       dec_comb;
    bcd_decode_t       dec_q;

    bcd_ctrl #(
        .LAT_NATIVE (LAT_NATIVE),
        .LAT_TABLE  (LAT_TABLE)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rdata        (mem_rdata),
        .handler_done (hdl_done),
        .mem_rd       (mem_rd),
        .pc_inc       (pc_inc),
        .resume       (resume),
        .out_load     (out_load),
        .start        (hdl_start),
        .waiting      (waiting),
        .byte0        (byte0)
    );

    bcd_pc #(
        .RESET_PC (RESET_PC)
    ) pc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (pc_inc),
        .load     (resume && pc_load),
        .load_val (pc_load_val),
        .pc       (pc)
    );

    bcd_decode #(
        .VPAGE (VPAGE)
    ) dec_i (
        .byte0 (byte0),
        .byte1 (mem_rdata),
        .dec   (dec_comb)
    );

    bcd_outreg out_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (out_load),
        .dec_in (dec_comb),
        .dec_q  (dec_q)
    );

    assign mem_addr   = pc;
    assign hdl_entry  = dec_q.entry;
    assign hdl_group  = dec_q.group;
    assign hdl_native = dec_q.native;
    assign hdl_xptr   = dec_q.xptr;
    assign hdl_yptr   = dec_q.yptr;

endmodule

// File: rtl/bcd_chk.sv
// Module: property checker for the dispatch unit, bound to the top.
module bcd_chk #(
    parameter logic [3:0] VPAGE = 4'hF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        hdl_start,
    input logic        hdl_native,
    input logic [3:0]  hdl_group,
    input logic [11:0] hdl_entry,
    input logic [11:0] hdl_xptr,
    input logic [11:0] hdl_yptr,
    input logic [11:0] mem_addr,
    input logic        hdl_done,
    input logic        mem_rd,
    input logic        waiting
);

    // R8: the start pulse lasts one cycle.
    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_start |=> !hdl_start);

    // R9: decode results and address hold while waiting.
    a_r9_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !hdl_done) |=> (waiting && $stable(hdl_entry) && $stable(hdl_group)
            && $stable(hdl_xptr) && $stable(hdl_yptr) && $stable(mem_addr)));

    // R10: completion in the wait state leads straight to a fetch.
    a_r10_resume_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && hdl_done) |=> (mem_rd && !waiting));

    // R12: no read request while waiting or starting.
    a_r12_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (!waiting && !hdl_start));

    // R3: a native start carries group 0.
    a_r3_native_group: assert property (@(posedge clk) disable iff (!rst_n)
        (hdl_start && hdl_native) |-> (hdl_group == 4'h0));

    // R5: table-group pointers lie in the top of the variable page.
    a_r5_ptr_page: assert property (@(posedge clk) disable iff (!rst_n)
        (hdl_start && !hdl_native) |-> ((hdl_xptr[11:4] == {VPAGE, 4'hF})
            && (hdl_yptr[11:4] == {VPAGE, 4'hF})));

endmodule

bind bcd_dispatch bcd_chk #(.VPAGE(VPAGE)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdl_start  (hdl_start),
    .hdl_native (hdl_native),
    .hdl_group  (hdl_group),
    .hdl_entry  (hdl_entry),
    .hdl_xptr   (hdl_xptr),
    .hdl_yptr   (hdl_yptr),
    .mem_addr   (mem_addr),
    .hdl_done   (hdl_done),
    .mem_rd     (mem_rd),
    .waiting    (waiting)
);

// File: tb/bcd_dispatch_tb_top.sv
// Bench: behavioural memory and handler model, compared every clock.
module bcd_dispatch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;
    logic        hdl_start;
    logic [11:0] hdl_entry;
    logic [3:0]  hdl_group;
    logic        hdl_native;
    logic [11:0] hdl_xptr;
    logic [11:0] hdl_yptr;
    logic        hdl_done;
    logic        pc_load;
    logic [11:0] pc_load_val;

    logic [7:0]  mem [0:4095];
    logic [11:0] pc_m;
    logic [11:0] px_m, py_m;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    bcd_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .hdl_start(hdl_start), .hdl_entry(hdl_entry),
        .hdl_group(hdl_group), .hdl_native(hdl_native), .hdl_xptr(hdl_xptr),
        .hdl_yptr(hdl_yptr), .hdl_done(hdl_done), .pc_load(pc_load),
        .pc_load_val(pc_load_val)
    );

    function automatic logic [11:0] ref_entry(input logic [3:0] g);
        case (g)
            4'h1: return 12'h17C;  4'h2: return 12'h175;  4'h3: return 12'h183;
            4'h4: return 12'h18B;  4'h5: return 12'h195;  4'h6: return 12'h1B4;
            4'h7: return 12'h1B7;  4'h8: return 12'h1BC;  4'h9: return 12'h191;
            4'hA: return 12'h1EB;  4'hB: return 12'h1A4;  4'hC: return 12'h1D9;
            4'hD: return 12'h070;  4'hE: return 12'h199;  4'hF: return 12'h105;
            default: return 12'h000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One instruction: fetch through start, handler wait, completion.
    task automatic do_instr(input int hold, input bit early, input bit ld,
                            input logic [11:0] ldv);
        logic [11:0] p, after, e_ent, e_x, e_y;
        logic [7:0]  b0, b1;
        logic [3:0]  g;
        bit          nat;
        int          lat;
        logic [11:0] s_ent, s_x, s_y;
        logic [3:0]  s_g;
        p     = pc_m;
        b0    = mem[p];
        b1    = mem[p + 12'd1];
        g     = b0[7:4];
        nat   = (g == 4'h0);
        lat   = nat ? 40 : 68;
        after = nat ? p + 12'd2 : p + 12'd1;
        e_ent = nat ? {b0[3:0], b1} : ref_entry(g);
        e_x   = nat ? px_m : {8'hFF, b0[3:0]};
        e_y   = nat ? py_m : {8'hFF, b1[7:4]};
        for (int c = 0; c <= lat; c++) begin
            if (c > 0) @(negedge clk);
            chk(mem_rd == (c <= 1), "R12", "mem_rd", mem_rd, (c <= 1));
            chk(mem_addr == ((c == 0) ? p : (c == 1) ? p + 12'd1 : after),
                nat ? "R3" : "R4", "mem_addr", mem_addr,
                (c == 0) ? p : (c == 1) ? p + 12'd1 : after);
            chk(hdl_start == (c == lat), early ? "R11" : "R8", "hdl_start",
                hdl_start, (c == lat));
            if (early && c == 10) begin
                hdl_done = 1'b1; pc_load = 1'b1; pc_load_val = 12'h555;
            end
            if (early && c == 14) begin
                hdl_done = 1'b0; pc_load = 1'b0;
            end
        end
        chk(hdl_group == g, "R2", "group", hdl_group, g);
        chk(hdl_native == nat, nat ? "R3" : "R4", "native", hdl_native, nat);
        chk(hdl_entry == e_ent, nat ? "R3" : "R7", "entry", hdl_entry, e_ent);
        chk(hdl_xptr == e_x, nat ? "R6" : "R5", "xptr", hdl_xptr, e_x);
        chk(hdl_yptr == e_y, nat ? "R6" : "R5", "yptr", hdl_yptr, e_y);
        s_ent = hdl_entry; s_x = hdl_xptr; s_y = hdl_yptr; s_g = hdl_group;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk(!hdl_start && !mem_rd, "R9", "idle while waiting",
                {hdl_start, mem_rd}, 0);
            chk(hdl_entry == s_ent && hdl_xptr == s_x && hdl_yptr == s_y &&
                hdl_group == s_g, "R9", "stable outputs", hdl_entry, s_ent);
            chk(mem_addr == after, "R9", "address held", mem_addr, after);
        end
        hdl_done = 1'b1; pc_load = ld; pc_load_val = ldv;
        @(negedge clk);
        hdl_done = 1'b0; pc_load = 1'b0;
        pc_m = ld ? ldv : after;
        chk(mem_rd && mem_addr == pc_m, "R10", "resume fetch", mem_addr, pc_m);
        px_m = e_x; py_m = e_y;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        mem[12'h200] = 8'h6A; mem[12'h201] = 8'h3C;
        mem[12'h202] = 8'h0A; mem[12'h203] = 8'hBC;
        mem[12'h204] = 8'hD1; mem[12'h205] = 8'hF5;
        mem[12'hFFF] = 8'h0F; mem[12'h000] = 8'hFF;
        mem[12'h300] = 8'hF0; mem[12'h301] = 8'h0E;
        mem[12'h302] = 8'h1E; mem[12'h303] = 8'h2D; mem[12'h304] = 8'h7B;
        for (int g = 1; g < 16; g++) begin
            mem[12'h400 + 2 * (g - 1)]     = {4'(g), 4'(g) ^ 4'h5};
            mem[12'h400 + 2 * (g - 1) + 1] = {~4'(g), 4'h3};
        end
        mem[12'h420] = 8'h00; mem[12'h421] = 8'h00;

        rst_n = 1'b0; hdl_done = 1'b0; pc_load = 1'b0; pc_load_val = '0;
        pc_m = 12'h200; px_m = '0; py_m = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_addr == 12'h200, "R1", "reset pc", mem_addr, 12'h200);
        chk(!hdl_start && hdl_group == 0 && hdl_entry == 0 && !hdl_native,
            "R1", "reset decode", hdl_entry, 0);
        chk(hdl_xptr == 0 && hdl_yptr == 0, "R1", "reset pointers", hdl_xptr, 0);
        rst_n = 1'b1;

        do_instr(3, 0, 1, 12'h202);     // table group 6
        do_instr(2, 0, 0, 12'h000);     // native, pointers held
        do_instr(1, 1, 1, 12'hFFF);     // early done/load ignored (R11)
        do_instr(2, 0, 1, 12'h300);     // native at top address, wraps
        do_instr(4, 0, 1, 12'h302);     // group F
        do_instr(1, 0, 0, 12'h000);     // group 1, no load
        do_instr(1, 0, 1, 12'h400);     // group 2 from odd address
        for (int g = 1; g < 16; g++) begin
            do_instr(1 + g % 3, 0, 1, pc_m + 12'd2);
        end
        do_instr(2, 0, 0, 12'h000);     // native to address 0

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule